// File: doc/BRIEF.md
# Erasable One-Time-Write Memory with Mode Control

This block is a synchronous behavioural model of an ultraviolet-erasable byte memory. The memory has a chip-select/program strobe (`ce_n`) and an output gate (`oe_n`). It also takes two flags that stand in for analog levels: `vpp_hi` says the programming supply is raised, and `sig_hv` says the identification voltage is present. The control inputs are sampled on every clock edge and decoded into one of six modes. The mode register then sets the output-enable and the data path on the following cycle. The data bus is split into `dq_in`, `dq_out` and a separate enable `dq_oe`, so a board-level wrapper can build the tri-state pin. A bench can also see high impedance directly.

Programming can only pull bits from 1 to 0. The address and data are captured while the program pulse is held. The AND-write is applied once, on the cycle in which the strobe rises to end the pulse. A single synchronous `erase` input returns every byte to all ones. An identification read returns two fixed bytes in place of array contents.

The mode register is an enumerated state machine with six states:
- `MD_STANDBY`
- `MD_READ`
- `MD_OUT_DIS`
- `MD_PROGRAM`
- `MD_VERIFY`
- `MD_INHIBIT`

Any state can move to any other state on the next decode. Two transitions out of `MD_PROGRAM` are named:
- **commit**: the strobe rises (the next state is `MD_STANDBY` or `MD_INHIBIT`). This writes the byte.
- **abort**: the next state is any other state with the strobe still low. This writes nothing.

Reset forces `MD_STANDBY`.

Top module: `eprom_model`

## Requirements
- R1: A cycle with `erase`=1 sets every byte to 0xFF. A read issued after that edge returns 0xFF at any address, and `erase` takes priority over a commit in the same cycle.
- R2: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=0 sampled at an edge (read mode), `dq_oe` is 1 after that edge, and `dq_out` holds the byte stored at the `addr` sampled on that edge.
- R3: With `ce_n`=1 and `vpp_hi`=0 (standby), `dq_oe` is 0 after the edge, whatever `oe_n` is.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output disable), `dq_oe` is 0 after the edge, and the stored contents are unchanged.
- R5: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=1 (program), `dq_oe` is 0 after the edge, and `addr` and `dq_in` are captured on each such edge.
- R6: Suppose the mode register holds program and `ce_n`=1 is sampled (commit). Then the byte at the captured address becomes its old value ANDed with the captured data, so bits only go from 1 to 0.
- R7: Leaving program while `ce_n` is still 0 (abort) writes nothing. This covers dropping `vpp_hi` and lowering `oe_n`.
- R8: With `ce_n`=1 and `vpp_hi`=1 (inhibit), `dq_oe` is 0 and no byte is written, whatever `addr` and `dq_in` hold.
- R9: With `ce_n`=0, `oe_n`=0 and `vpp_hi`=1 (verify), `dq_oe` is 1 after the edge, and `dq_out` holds the stored byte at the sampled `addr`.
- R10: In read or verify with `sig_hv`=1, `dq_out` is 0x8F when `addr` bit 0 is 0 and 0x85 when it is 1, in place of array data.
- R11: `rst_n`=0 sampled at an edge forces standby: `dq_oe`=0 and `dq_out`=0x00. Reset does not alter the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select / program strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply raised |
| sig_hv | input | 1 | Identification voltage present |
| erase | input | 1 | Synchronous erase of all bytes to 0xFF |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Program data from the pins |
| dq_out | output | 8 | Data driven toward the pins |
| dq_oe | output | 1 | Pin driver enable; 0 means high impedance |

## Verification
The checker covers the mode-to-pin mapping on every clocked cycle:
- The bus is never driven in standby, inhibit, output disable or program.
- It is always driven after a read or verify decode.
- The identification bytes appear whenever the identification flag is set.
- An array write happens only right after a program cycle, on a sampled high strobe.

Only the bench's scenarios can show what is stored. That covers the AND-only update, erase priority, the absence of any write on abort or inhibit, and the match between reads and a reference image. The bench shows these by comparing reads against its own copy of the memory, across random program, read, verify and erase sequences.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SIG_MFR = 8'h8F;
    localparam logic [BYTE_W-1:0] SIG_DEV = 8'h85;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OUT_DIS,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } mode_e;
endpackage

// File: rtl/eprom_mode_fsm.sv
module eprom_mode_fsm
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output mode_e             mode_q,
    output mode_e             mode_nx,
    output logic              commit_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    // Mode decode from the sampled control pins
    always_comb begin
        unique case ({ce_n, oe_n, vpp_hi})
            3'b000:         mode_nx = MD_READ;
            3'b001:         mode_nx = MD_VERIFY;
            3'b010:         mode_nx = MD_OUT_DIS;
            3'b011:         mode_nx = MD_PROGRAM;
            3'b100, 3'b110: mode_nx = MD_STANDBY;
            3'b101, 3'b111: mode_nx = MD_INHIBIT;
            default:        mode_nx = MD_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_STANDBY;
        end else begin
            mode_q <= mode_nx;
        end
    end

    // Capture target while the program pulse is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (mode_nx == MD_PROGRAM) begin
            wr_addr <= addr;
            wr_data <= din;
        end
    end

    // Commit transition: PROGRAM left by a rising strobe
    assign commit_en = rst_n && (mode_q == MD_PROGRAM) && ce_n;
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              erase,
    input  logic              commit_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= {BYTE_W{1'b1}};
            end
        end else if (commit_en) begin
            cells[wr_addr] <= cells[wr_addr] & wr_data;
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/eprom_out_stage.sv
module eprom_out_stage
    import eprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode_q,
    input  mode_e             mode_nx,
    input  logic              sig_hv,
    input  logic              addr0,
    input  logic [BYTE_W-1:0] arr_data,
    output logic [BYTE_W-1:0] dq_out,
    output logic              dq_oe
);
    logic load_nx;

    always_comb begin
        unique case (mode_nx)
            MD_READ, MD_VERIFY: load_nx = 1'b1;
            default:            load_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
        end else if (load_nx) begin
            if (sig_hv) begin
                dq_out <= addr0 ? SIG_DEV : SIG_MFR;
            end else begin
                dq_out <= arr_data;
            end
        end
    end

    always_comb begin
        unique case (mode_q)
            MD_READ, MD_VERIFY:                       dq_oe = 1'b1;
            MD_STANDBY, MD_OUT_DIS, MD_PROGRAM,
            MD_INHIBIT:                               dq_oe = 1'b0;
            default:                                  dq_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/eprom_model.sv
module eprom_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hi,
    input  logic              sig_hv,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe
);
    mode_e             mode_q;
    mode_e             mode_nx;
    logic              commit_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] arr_data;

    eprom_mode_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_hi    (vpp_hi),
        .addr      (addr),
        .din       (dq_in),
        .mode_q    (mode_q),
        .mode_nx   (mode_nx),
        .commit_en (commit_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    eprom_cell_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .erase     (erase),
        .commit_en (commit_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (addr),
        .rd_data   (arr_data)
    );

    eprom_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .mode_nx  (mode_nx),
        .sig_hv   (sig_hv),
        .addr0    (addr[0]),
        .arr_data (arr_data),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       vpp_hi,
    input logic       sig_hv,
    input logic       addr0,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic       commit_en
);
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi) |=> dq_oe);

    p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |=> !dq_oe);

    p_outdis_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |=> !dq_oe);

    p_prog_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && vpp_hi) |=> !dq_oe);

    // R6 / R7: a write only follows a program cycle and a high strobe
    p_commit_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (ce_n && $past(!ce_n && oe_n && vpp_hi)));

    p_inhibit_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && vpp_hi) |=> !dq_oe);

    p_verify_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && vpp_hi) |=> dq_oe);

    p_sig_mfr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && sig_hv && !addr0) |=> (dq_oe && dq_out == 8'h8F));

    p_sig_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && sig_hv && addr0) |=> (dq_oe && dq_out == 8'h85));
endmodule

bind eprom_model eprom_model_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .vpp_hi    (vpp_hi),
    .sig_hv    (sig_hv),
    .addr0     (addr[0]),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .commit_en (commit_en)
);

// File: tb/test_eprom_model.sv
module test_eprom_model;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, vpp_hi, sig_hv, erase;
    logic [AW-1:0] addr;
    logic [7:0]    dq_in;
    logic [7:0]    dq_out;
    logic          dq_oe;

    logic [7:0] img [DEPTH];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    eprom_model #(.ADDR_W(AW)) i_eprom_model (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
        .sig_hv(sig_hv), .erase(erase), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [7:0] sig_code(input logic a0);
        return a0 ? 8'h85 : 8'h8F;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic set_ctl(input logic c, input logic o, input logic v);
        ce_n = c; oe_n = o; vpp_hi = v;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic sg, input logic v, input string req);
        logic [7:0] e;
        set_ctl(1'b0, 1'b0, v); sig_hv = sg; addr = a;
        cyc();
        e = sg ? sig_code(a[0]) : img[a];
        chk(dq_oe === 1'b1, req, {7'd0, dq_oe}, 8'd1);
        chk(dq_out === e, req, dq_out, e);
        sig_hv = 1'b0;
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d);
        set_ctl(1'b0, 1'b1, 1'b1); addr = a; dq_in = d;
        cyc();
        chk(dq_oe === 1'b0, "R5 program hiz", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b1;
        cyc();
        chk(dq_oe === 1'b0, "R8 inhibit hiz", {7'd0, dq_oe}, 8'd0);
        img[a] = img[a] & d;
    endtask

    task automatic do_erase();
        set_ctl(1'b1, 1'b1, 1'b0); erase = 1'b1;
        cyc();
        erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) img[i] = 8'hFF;
    endtask

    initial begin
        int seed;
        logic [AW-1:0] a;
        logic [7:0] d;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; erase = 1'b0; sig_hv = 1'b0;
        set_ctl(1'b0, 1'b0, 1'b0); addr = '0; dq_in = '0;
        cyc(); cyc();
        // R11: read requested during reset still shows standby
        chk(dq_oe === 1'b0, "R11 reset oe", {7'd0, dq_oe}, 8'd0);
        chk(dq_out === 8'h00, "R11 reset data", dq_out, 8'h00);
        rst_n = 1'b1;

        // R1: erase then read back all ones
        do_erase();
        do_read(10'd0, 1'b0, 1'b0, "R1 erased");
        do_read(10'd1023, 1'b0, 1'b0, "R1 erased");

        // R6: AND-only update
        do_prog(10'd5, 8'h0F);
        do_read(10'd5, 1'b0, 1'b0, "R6 first write");
        do_prog(10'd5, 8'hF3);
        do_read(10'd5, 1'b0, 1'b0, "R6 bits only clear");
        chk(img[5] === 8'h03, "R6 model", img[5], 8'h03);

        // R7: abort by dropping vpp, then by lowering oe (verify)
        set_ctl(1'b0, 1'b1, 1'b1); addr = 10'd7; dq_in = 8'h00; cyc();
        vpp_hi = 1'b0; cyc();
        chk(dq_oe === 1'b0, "R4 outdis hiz", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b1; cyc();
        do_read(10'd7, 1'b0, 1'b0, "R7 abort via vpp");
        set_ctl(1'b0, 1'b1, 1'b1); addr = 10'd7; dq_in = 8'h00; cyc();
        do_read(10'd7, 1'b0, 1'b1, "R7 abort via oe / R9 verify");
        ce_n = 1'b1; cyc();
        do_read(10'd7, 1'b0, 1'b0, "R7 abort no write");

        // R8: inhibit with data present never writes
        set_ctl(1'b1, 1'b1, 1'b1); addr = 10'd9; dq_in = 8'h00; cyc(); cyc();
        chk(dq_oe === 1'b0, "R8 inhibit hiz", {7'd0, dq_oe}, 8'd0);
        do_read(10'd9, 1'b0, 1'b0, "R8 no write");

        // R3: standby with oe low
        set_ctl(1'b1, 1'b0, 1'b0); cyc();
        chk(dq_oe === 1'b0, "R3 standby hiz", {7'd0, dq_oe}, 8'd0);

        // R4: output disable leaves contents
        set_ctl(1'b0, 1'b1, 1'b0); addr = 10'd5; dq_in = 8'h00; cyc();
        chk(dq_oe === 1'b0, "R4 outdis hiz", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b1; cyc();
        do_read(10'd5, 1'b0, 1'b0, "R4 unchanged");

        // R10: identification bytes in read and verify
        do_read(10'd0, 1'b1, 1'b0, "R10 mfr code");
        do_read(10'd1, 1'b1, 1'b0, "R10 dev code");
        do_read(10'd2, 1'b1, 1'b1, "R10 verify mfr");

        // R1: erase wins over a commit in the same cycle
        set_ctl(1'b0, 1'b1, 1'b1); addr = 10'd11; dq_in = 8'h00; cyc();
        ce_n = 1'b1; erase = 1'b1; cyc();
        erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) img[i] = 8'hFF;
        do_read(10'd11, 1'b0, 1'b0, "R1 erase priority");
        do_read(10'd5, 1'b0, 1'b0, "R1 erase clears");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = $urandom_range(0, 9);
            a = AW'($urandom_range(0, DEPTH - 1));
            d = 8'($urandom);
            if (op < 3) begin
                do_prog(a, d);
            end else if (op < 6) begin
                do_read(a, 1'b0, 1'b0, "R2 random read");
            end else if (op == 6) begin
                do_read(a, 1'b0, 1'b1, "R9 random verify");
            end else if (op == 7) begin
                do_read(a, 1'b1, 1'($urandom_range(0, 1)), "R10 random sig");
            end else if (op == 8) begin
                set_ctl(1'($urandom_range(0, 1)), 1'b1, 1'b0); addr = a; dq_in = d; cyc();
                chk(dq_oe === 1'b0, "R3 R4 random hiz", {7'd0, dq_oe}, 8'd0);
            end else if (n % 200 == 8) begin
                do_erase();
            end
        end

        // R11: reset keeps the array
        do_prog(10'd3, 8'h5A);
        rst_n = 1'b0; set_ctl(1'b1, 1'b1, 1'b0); cyc();
        rst_n = 1'b1;
        do_read(10'd3, 1'b0, 1'b0, "R11 array kept");

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule